// File: doc/BRIEF.md
# Two-Level Lookahead 16-Bit Adder

This block adds two 16-bit operands and a carry-in and produces a 16-bit sum and a carry-out, with no clock and no state. The operand width is cut into four slices of four bits. Every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each slice resolves its own internal carries from those terms and its incoming carry. It also summarises itself as one slice generate and one slice propagate.

A second lookahead stage takes the four slice summaries and the adder carry-in. It forms the carries into slices one to three, and the carry-out, as flat sum-of-products expressions. No carry travels serially from one slice to the next. The block is meant for a datapath where an addition must settle within one cycle. It has no subtract control and no overflow flag.

Top module: `cla16_two_level`

## Requirements
- R1: With both operands zero and carry-in low, the sum is 0x0000 and the carry-out is 0.
- R2: The sum equals the low 16 bits of op_a + op_b + carry_in for any inputs, and it follows an input change without any clock edge.
- R3: The carry-out equals bit 16 of the 17-bit value op_a + op_b + carry_in.
- R4: With op_a = 0xFFFF, op_b = 0x0000 and carry_in = 1, the sum is 0x0000 and the carry-out is 1: a carry crosses every slice.
- R5: A carry generated in the lowest slice reaches slices one to three through propagation only. For example, 0x000F + 0xFFF1 gives sum 0x0000 and carry-out 1.
- R6: When no bit position has both operand bits set, the sum with carry-in low is op_a | op_b and the carry-out is 0. With carry-in high and op_a | op_b = 0xFFFF, the sum is 0x0000 and the carry-out is 1.
- R7: When bit 15 is set in both operands, the carry-out is 1 whatever the lower bits are.
- R8: A carry leaving bit 3, 7 or 11 enters bit 4, 8 or 12. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R9: Exchanging op_a and op_b leaves the sum and the carry-out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Two functions can meet in one evaluation:
- a carry born in the lowest slice and carried upward by the second-level terms;
- a generate inside the top slice that sets the carry-out by itself.

Directed vectors such as 0x800F + 0x8001 and 0xFFFF + 0x8001 provoke both at once. They are judged against the 17-bit integer sum. The same applies to the all-ones-plus-one and alternating-pattern cases and to thousands of random operand pairs, each also applied with the operands swapped.

// File: rtl/cla16_two_level.sv
module cla16_two_level #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4
) (
  input  logic [GROUP_W*GROUPS-1:0] op_a,
  input  logic [GROUP_W*GROUPS-1:0] op_b,
  input  logic                      carry_in,
  output logic [GROUP_W*GROUPS-1:0] sum,
  output logic                      carry_out
);
  localparam int WIDTH = GROUP_W * GROUPS;

  // Carry into position n from n generate/propagate pairs, as flat sum of products.
  function automatic logic lookahead(input logic [WIDTH-1:0] g, input logic [WIDTH-1:0] p,
                                     input logic c0, input int n);
    logic acc, term;
    acc = c0;
    for (int m = 0; m < n; m++) acc = acc & p[m];
    for (int k = 0; k < n; k++) begin
      term = g[k];
      for (int m = k + 1; m < n; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  logic [WIDTH-1:0]  bit_g, bit_p, bit_c;
  logic [GROUPS-1:0] grp_g, grp_p;
  logic [GROUPS:0]   grp_c;

  assign bit_g = op_a & op_b;
  assign bit_p = op_a | op_b;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_slice
    localparam int BASE = gi * GROUP_W;
    logic [WIDTH-1:0] sg, sp;
    assign sg = {{(WIDTH-GROUP_W){1'b0}}, bit_g[BASE +: GROUP_W]};
    assign sp = {{(WIDTH-GROUP_W){1'b0}}, bit_p[BASE +: GROUP_W]};
    assign grp_p[gi] = &bit_p[BASE +: GROUP_W];
    assign grp_g[gi] = lookahead(sg, sp, 1'b0, GROUP_W);
    for (genvar j = 0; j < GROUP_W; j++) begin : g_bit
      assign bit_c[BASE + j] = lookahead(sg, sp, grp_c[gi], j);
    end
  end

  logic [WIDTH-1:0] top_g, top_p;
  assign top_g    = {{(WIDTH-GROUPS){1'b0}}, grp_g};
  assign top_p    = {{(WIDTH-GROUPS){1'b0}}, grp_p};
  assign grp_c[0] = carry_in;
  for (genvar j = 1; j <= GROUPS; j++) begin : g_top
    assign grp_c[j] = lookahead(top_g, top_p, carry_in, j);
  end

  assign sum       = op_a ^ op_b ^ bit_c;
  assign carry_out = grp_c[GROUPS];

  always_comb begin
    a_r3_total: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("total mismatch");
    a_r4_all_ones: assert (!(op_a == {WIDTH{1'b1}} && op_b == '0 && carry_in) || (sum == '0 && carry_out))
      else $error("all-ones carry lost");
    a_r6_no_generate: assert (!((op_a & op_b) == '0 && !carry_in) || (sum == (op_a | op_b) && !carry_out))
      else $error("spurious carry");
    a_r7_top_generate: assert (!(op_a[WIDTH-1] && op_b[WIDTH-1]) || carry_out)
      else $error("top generate missed");
  end

  for (genvar gi = 1; gi < GROUPS; gi++) begin : g_chk
    localparam int BASE = gi * GROUP_W;
    always_comb begin
      logic [WIDTH:0] lo;
      lo = {1'b0, op_a & ((WIDTH)'(1 << BASE) - 1'b1)} + {1'b0, op_b & ((WIDTH)'(1 << BASE) - 1'b1)}
           + {{WIDTH{1'b0}}, carry_in};
      a_r5_group_carry: assert (grp_c[gi] == lo[BASE]) else $error("slice carry wrong");
    end
  end
endmodule

// File: tb/sim_cla16_two_level.sv
`timescale 1ns/1ps
module sim_cla16_two_level;
  logic clk = 0, rst_n = 0;
  logic [15:0] a = '0, b = '0, s;
  logic cin = 0, cout;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [15:0] es; logic ec; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  cla16_two_level u0 (.op_a(a), .op_b(b), .carry_in(cin), .sum(s), .carry_out(cout));

  task automatic send(input logic [15:0] x, input logic [15:0] y, input logic c, input string tag);
    logic [16:0] t;
    @(posedge clk);
    a = x; b = y; cin = c;
    t = {1'b0, x} + {1'b0, y} + {16'b0, c};
    q.push_back('{t[15:0], t[16], tag});
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (s !== it.es || cout !== it.ec) begin
        fails++;
        $display("FAIL %s a=%h b=%h cin=%0d got sum=%h cout=%0d expected sum=%h cout=%0d",
                 it.tag, a, b, cin, s, cout, it.es, it.ec);
      end
    end
  end

  initial begin
    logic [15:0] x, y;
    repeat (3) @(posedge clk);
    rst_n = 1;
    send(16'h0000, 16'h0000, 1'b0, "R1");
    send(16'h1234, 16'h4321, 1'b0, "R2");
    send(16'hFFFF, 16'hFFFF, 1'b1, "R3");
    send(16'hFFFF, 16'h0000, 1'b1, "R4");
    send(16'h0000, 16'hFFFF, 1'b1, "R4");
    send(16'hFFFF, 16'h0001, 1'b0, "R4");
    send(16'h000F, 16'hFFF1, 1'b0, "R5");
    send(16'h00FF, 16'hFF01, 1'b0, "R5");
    send(16'hAAAA, 16'h5555, 1'b0, "R6");
    send(16'hAAAA, 16'h5555, 1'b1, "R6");
    send(16'h0F0F, 16'h30C0, 1'b0, "R6");
    send(16'h8000, 16'h8000, 1'b0, "R7");
    send(16'h800F, 16'h8001, 1'b0, "R7");
    send(16'hFFFF, 16'h8001, 1'b0, "R7");
    send(16'h000F, 16'h0001, 1'b0, "R8");
    send(16'h00FF, 16'h0001, 1'b0, "R8");
    send(16'h0FFF, 16'h0001, 1'b0, "R8");
    send(16'h0007, 16'h0008, 1'b1, "R8");
    for (int i = 0; i < 512; i++) send(16'(i[3:0]) << 4, 16'(i[7:4]) << 4, i[8], "R8");
    for (int i = 0; i < 3000; i++) begin
      x = 16'($urandom); y = 16'($urandom);
      send(x, y, 1'($urandom), "R2 R3");
      send(y, x, cin, "R9");
    end
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule